// File: doc/BRIEF.md
# Up/Down Auto-Reload Timer/Counter

This block is a 16-bit timer/counter. Its count is kept as two 8-bit halves, and a carry or borrow passes from the low half to the high half. The count advances on one of two sources. The first is a free-running prescaler that fires once every 12 system clocks. The second is a falling edge on an external event pin, which passes through a two-stage synchroniser before edge detection. Software drives the block through a byte-wide write port and a read-select mux. Through these it reaches:

- the two count bytes,
- the two reload bytes,
- a control byte holding the run bit, the source select, the down-count enable, the sticky wrap flag and a read-only extension bit.

With down-count enable clear, the block counts up only. Past FFFFh it reloads from the reload register and raises the wrap flag. With down-count enable set, the direction pin selects the direction. Counting up behaves as above. Counting down wraps when the count equals the reload value: the count then becomes FFFFh. In this mode every wrap also toggles an extension bit, which gives a 17th bit of resolution without raising any interrupt. The interrupt request is the wrap flag gated by an enable input.

Top module: `updn_timer`

## Requirements
- R1: The count is 16 bits. Select 0 accesses its low byte and select 1 its high byte. A step up from xxFFh carries into the high byte, and a step down from xx00h borrows from it.
- R2: With control bit 1 clear, the count steps once every 12 clocks from a prescaler that runs freely and ignores the run bit. With control bit 1 set, it steps once per falling edge of `ev_in`.
- R3: With the run bit (control bit 0) clear, the count does not change for any source activity.
- R4: With down-count enable (control bit 2) clear, the count only rises. A step from FFFFh loads the reload value (select 2 low byte, select 3 high byte) and sets the wrap flag. The extension bit does not change.
- R5: With down-count enable set and `dir_in` high, the count rises. A step from FFFFh loads the reload value, sets the wrap flag and toggles the extension bit.
- R6: With down-count enable set and `dir_in` low, the count falls. A step taken when the count equals the reload value loads FFFFh, sets the wrap flag and toggles the extension bit. A step from 0000h in any other case gives FFFFh without setting the flag.
- R7: The wrap flag stays set until software writes the control byte (select 4) with bit 3 at 0; writing bit 3 as 1 leaves the flag alone. A wrap in the same cycle as such a clearing write leaves the flag set.
- R8: A write to either count byte in the cycle of a step takes the written value. The step is dropped, together with its flag and extension effects.
- R9: `irq` is high exactly when the wrap flag is set and `irq_en` is high.
- R10: A read of the control byte returns the run, source and down-enable bits in bits 0 to 2, the wrap flag in bit 3 and the extension bit in bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 8 | Read data (combinational) |
| ev_in | input | 1 | External event input (asynchronous) |
| dir_in | input | 1 | Count direction when down-count is enabled (1 = up) |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |
| ovf_flag | output | 1 | Sticky wrap flag |
| ext_bit | output | 1 | Extension bit, toggles on each up/down-mode wrap |

## Verification
The bench sweeps event-by-event through wraps in each direction mode and compares the count, flag and extension bit against an arithmetic model after every step. A design that compared the down-wrap against zero instead of the reload value, or toggled the extension bit in plain up mode, would diverge within a few steps. Byte-boundary starts catch a broken carry or borrow. Two tests align a software write with the exact edge on which a synchronised event lands, one on the flag and one on a count byte. These expose a design that lets the software clear beat a wrap, or that lets a step overwrite a software load. A 120-cycle window in prescaled mode must give exactly ten steps, so a prescaler off by one or restarted by the run bit shows at once.

// File: rtl/updn_tmr_pkg.sv
`timescale 1ns/1ps
package updn_tmr_pkg;
    localparam int HALF_W   = 8;
    localparam int PRESCALE = 12;

    typedef enum logic [2:0] {
        SEL_CNT_LO = 3'd0,
        SEL_CNT_HI = 3'd1,
        SEL_RLD_LO = 3'd2,
        SEL_RLD_HI = 3'd3,
        SEL_CTRL   = 3'd4
    } reg_sel_e;

    // control bit positions
    localparam int CB_RUN  = 0;
    localparam int CB_SRC  = 1;
    localparam int CB_DN   = 2;
    localparam int CB_FLAG = 3;
    localparam int CB_EXT  = 4;

    typedef struct packed {
        logic dn_en;
        logic ev_src;
        logic run;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2
    } step_e;

    function automatic step_e pick_step(input logic tick, input logic dn_en, input logic dir);
        if (!tick)              return ST_HOLD;
        else if (!dn_en || dir) return ST_UP;
        else                    return ST_DOWN;
    endfunction
endpackage

// File: rtl/updn_tick_gen.sv
`timescale 1ns/1ps
module updn_tick_gen #(
    parameter int PRESCALE = updn_tmr_pkg::PRESCALE
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic ev_src,
    input  logic ev_in,
    output logic tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] PTOP = PW'(PRESCALE - 1);

    logic [PW-1:0] pre_q;
    logic          pre_pulse;
    logic [2:0]    sync_q;   // [0],[1] synchroniser, [2] previous sample
    logic          ev_fall;

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= (pre_q == PTOP) ? '0 : pre_q + 1'b1;
    end

    assign pre_pulse = (pre_q == PTOP);

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 3'b111;
        else     sync_q <= {sync_q[1:0], ev_in};
    end

    assign ev_fall = sync_q[2] & ~sync_q[1];
    assign tick    = run & (ev_src ? ev_fall : pre_pulse);

    // R2
    pre_single_chk: assert property (@(posedge clk) disable iff (rst)
        pre_pulse |=> !pre_pulse);
    // R2
    fall_single_chk: assert property (@(posedge clk) disable iff (rst)
        ev_fall |=> !ev_fall);
endmodule

// File: rtl/updn_count_core.sv
`timescale 1ns/1ps
module updn_count_core
    import updn_tmr_pkg::*;
#(
    parameter int HALF_W = updn_tmr_pkg::HALF_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  dn_en,
    input  logic                  dir,
    input  logic [2*HALF_W-1:0]   rld,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic [HALF_W-1:0]     wr_data,
    output logic [2*HALF_W-1:0]   cnt,
    output logic                  wrap,
    output logic                  ext_bit
);
    localparam int CNT_W = 2 * HALF_W;
    localparam logic [CNT_W-1:0] ALL1 = '1;

    logic [HALF_W-1:0] lo_q, hi_q;
    logic [CNT_W-1:0]  nxt;
    logic              raw_wrap;
    logic              sw_wr;
    step_e             st;

    assign cnt   = {hi_q, lo_q};
    assign sw_wr = wr_lo | wr_hi;
    assign st    = pick_step(tick, dn_en, dir);

    always_comb begin
        nxt      = cnt;
        raw_wrap = 1'b0;
        unique case (st)
            ST_UP: begin
                if (cnt == ALL1) begin
                    nxt      = rld;
                    raw_wrap = 1'b1;
                end else begin
                    nxt = cnt + 1'b1;
                end
            end
            ST_DOWN: begin
                if (cnt == rld) begin
                    nxt      = ALL1;
                    raw_wrap = 1'b1;
                end else begin
                    nxt = cnt - 1'b1;
                end
            end
            default: ;
        endcase
    end

    assign wrap = raw_wrap & ~sw_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q    <= '0;
            hi_q    <= '0;
            ext_bit <= 1'b0;
        end else begin
            if (sw_wr) begin
                if (wr_lo) lo_q <= wr_data;
                if (wr_hi) hi_q <= wr_data;
            end else begin
                {hi_q, lo_q} <= nxt;
            end
            if (wrap && dn_en) ext_bit <= ~ext_bit;
        end
    end

    // R4
    up_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !sw_wr && (!dn_en || dir) && cnt == ALL1) |=> cnt == $past(rld));
    // R6
    down_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !sw_wr && dn_en && !dir && cnt == rld) |=> (cnt == ALL1 && ext_bit != $past(ext_bit)));
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !sw_wr) |=> $stable(cnt));
    // R4
    ext_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !dn_en |=> $stable(ext_bit));
endmodule

// File: rtl/updn_timer.sv
`timescale 1ns/1ps
module updn_timer
    import updn_tmr_pkg::*;
#(
    parameter int HALF_W   = updn_tmr_pkg::HALF_W,
    parameter int PRESCALE = updn_tmr_pkg::PRESCALE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [HALF_W-1:0] wr_data,
    input  logic [2:0]        rd_sel,
    output logic [HALF_W-1:0] rd_data,
    input  logic              ev_in,
    input  logic              dir_in,
    input  logic              irq_en,
    output logic              irq,
    output logic              ovf_flag,
    output logic              ext_bit
);
    localparam int CNT_W = 2 * HALF_W;

    ctrl_t             ctrl_q;
    logic [HALF_W-1:0] rld_lo_q, rld_hi_q;
    logic [CNT_W-1:0]  cnt;
    logic              tick, wrap, flag_clr;
    reg_sel_e          wsel, rsel;

    assign wsel     = reg_sel_e'(wr_sel);
    assign rsel     = reg_sel_e'(rd_sel);
    assign flag_clr = wr_en && (wsel == SEL_CTRL) && !wr_data[CB_FLAG];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            rld_lo_q <= '0;
            rld_hi_q <= '0;
            ovf_flag <= 1'b0;
        end else begin
            if (wr_en) begin
                unique case (wsel)
                    SEL_RLD_LO: rld_lo_q <= wr_data;
                    SEL_RLD_HI: rld_hi_q <= wr_data;
                    SEL_CTRL:   ctrl_q   <= '{dn_en:  wr_data[CB_DN],
                                              ev_src: wr_data[CB_SRC],
                                              run:    wr_data[CB_RUN]};
                    default: ;
                endcase
            end
            if (wrap)          ovf_flag <= 1'b1;
            else if (flag_clr) ovf_flag <= 1'b0;
        end
    end

    updn_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .run    (ctrl_q.run),
        .ev_src (ctrl_q.ev_src),
        .ev_in  (ev_in),
        .tick   (tick)
    );

    updn_count_core #(.HALF_W(HALF_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .dn_en   (ctrl_q.dn_en),
        .dir     (dir_in),
        .rld     ({rld_hi_q, rld_lo_q}),
        .wr_lo   (wr_en && wsel == SEL_CNT_LO),
        .wr_hi   (wr_en && wsel == SEL_CNT_HI),
        .wr_data (wr_data),
        .cnt     (cnt),
        .wrap    (wrap),
        .ext_bit (ext_bit)
    );

    always_comb begin
        rd_data = '0;
        unique case (rsel)
            SEL_CNT_LO: rd_data = cnt[HALF_W-1:0];
            SEL_CNT_HI: rd_data = cnt[CNT_W-1:HALF_W];
            SEL_RLD_LO: rd_data = rld_lo_q;
            SEL_RLD_HI: rd_data = rld_hi_q;
            SEL_CTRL: begin
                rd_data[CB_RUN]  = ctrl_q.run;
                rd_data[CB_SRC]  = ctrl_q.ev_src;
                rd_data[CB_DN]   = ctrl_q.dn_en;
                rd_data[CB_FLAG] = ovf_flag;
                rd_data[CB_EXT]  = ext_bit;
            end
            default: ;
        endcase
    end

    assign irq = ovf_flag & irq_en;

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !flag_clr) |=> ovf_flag);
    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> ovf_flag);
    // R9
    irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ovf_flag);
endmodule

// File: tb/tb_updn_timer.sv
`timescale 1ns/1ps
module tb_updn_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_sel = '0;
    logic [7:0] rd_data;
    logic       ev_in = 1'b1;
    logic       dir_in = 1'b1;
    logic       irq_en = 1'b0;
    logic       irq, ovf_flag, ext_bit;

    int checks = 0;
    int errors = 0;

    logic [15:0] m_cnt;
    logic        m_flag, m_ext;

    always #5 clk = ~clk;

    updn_timer dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .ev_in(ev_in), .dir_in(dir_in),
        .irq_en(irq_en), .irq(irq), .ovf_flag(ovf_flag), .ext_bit(ext_bit)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd16(output logic [15:0] v);
        rd_sel = 3'd0; #1 v[7:0] = rd_data;
        rd_sel = 3'd1; #1 v[15:8] = rd_data;
    endtask

    task automatic rdc(output logic [7:0] v);
        rd_sel = 3'd4; #1 v = rd_data;
    endtask

    // ctrl byte: bit0 run, bit1 source (1 = events), bit2 down enable, bit3 = 0 clears flag
    task automatic set_ctrl(input logic run, input logic src, input logic dn, input logic keep);
        wr(3'd4, {4'b0, keep, dn, src, run});
    endtask

    task automatic load16(input logic [15:0] v);
        wr(3'd0, v[7:0]); wr(3'd1, v[15:8]);
    endtask

    task automatic rld16(input logic [15:0] v);
        wr(3'd2, v[7:0]); wr(3'd3, v[15:8]);
    endtask

    task automatic ev_pulse;
        @(negedge clk); ev_in = 1'b0;
        repeat (4) @(negedge clk);
        ev_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic model_step(input logic [15:0] rld, input logic dn, input logic dir);
        if (!dn || dir) begin
            if (m_cnt == 16'hFFFF) begin
                m_cnt = rld; m_flag = 1'b1;
                if (dn) m_ext = ~m_ext;
            end else m_cnt = m_cnt + 16'd1;
        end else begin
            if (m_cnt == rld) begin
                m_cnt = 16'hFFFF; m_flag = 1'b1; m_ext = ~m_ext;
            end else m_cnt = m_cnt - 16'd1;
        end
    endtask

    task automatic sweep(input string tag, input logic dn, input logic dir,
                         input logic [15:0] rld, input logic [15:0] start, input int n);
        logic [15:0] v;
        logic [7:0]  c;
        set_ctrl(1'b0, 1'b1, dn, 1'b0);
        rld16(rld);
        load16(start);
        dir_in = dir;
        m_cnt = start; m_flag = 1'b0;
        set_ctrl(1'b1, 1'b1, dn, 1'b1);
        for (int i = 0; i < n; i++) begin
            ev_pulse();
            model_step(rld, dn, dir);
            rd16(v);
            chk({tag, " count"}, {16'd0, v}, {16'd0, m_cnt});
            chk({tag, " flag"}, {31'd0, ovf_flag}, {31'd0, m_flag});
            chk({tag, " ext"}, {31'd0, ext_bit}, {31'd0, m_ext});
        end
        rdc(c);
        // R10 ctrl read layout
        chk("R10 ctrl", {24'd0, c}, {27'd0, m_ext, m_flag, dn, 1'b1, 1'b1});
        set_ctrl(1'b0, 1'b1, dn, 1'b1);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  c;
        m_ext = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        rd16(v);
        chk("reset count", {16'd0, v}, 32'd0);
        chk("reset flag", {31'd0, ovf_flag}, 32'd0);
        chk("reset ext", {31'd0, ext_bit}, 32'd0);
        chk("reset irq", {31'd0, irq}, 32'd0);

        // R1 carry and borrow between bytes
        sweep("R1 carry", 1'b0, 1'b1, 16'h0000, 16'h00FD, 5);
        sweep("R1 borrow", 1'b1, 1'b0, 16'h0005, 16'h0202, 5);
        // R4 up only, reload past FFFF, ext untouched
        sweep("R4", 1'b0, 1'b0, 16'hFFF0, 16'hFFFA, 40);
        // R5 up/down mode counting up
        sweep("R5", 1'b1, 1'b1, 16'hFFFC, 16'hFFFD, 12);
        // R6 down, wrap at reload value
        sweep("R6", 1'b1, 1'b0, 16'h0100, 16'h0103, 12);
        // R6 passing zero is not a wrap
        sweep("R6 zero", 1'b1, 1'b0, 16'h8000, 16'h0002, 5);

        // R3 run clear: events do nothing
        load16(16'h4321);
        set_ctrl(1'b0, 1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 3; i++) ev_pulse();
        rd16(v);
        chk("R3 halted", {16'd0, v}, 32'h4321);

        // R2 prescaled source: 120 clocks -> 10 steps
        load16(16'h0000);
        set_ctrl(1'b1, 1'b0, 1'b0, 1'b1);
        repeat (119) @(posedge clk);
        set_ctrl(1'b0, 1'b0, 1'b0, 1'b1);
        rd16(v);
        chk("R2 prescale", {16'd0, v}, 32'd10);
        // R2 event source while prescaler runs: only edges count
        load16(16'h0000);
        set_ctrl(1'b1, 1'b1, 1'b0, 1'b1);
        repeat (50) @(negedge clk);
        ev_pulse(); ev_pulse();
        set_ctrl(1'b0, 1'b1, 1'b0, 1'b1);
        rd16(v);
        chk("R2 events", {16'd0, v}, 32'd2);

        // R7 clear
        set_ctrl(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R7 cleared", {31'd0, ovf_flag}, 32'd0);
        // R7 set wins against clear in same cycle
        rld16(16'h0011);
        load16(16'hFFFF);
        set_ctrl(1'b1, 1'b1, 1'b0, 1'b1);
        @(negedge clk); ev_in = 1'b0;
        @(posedge clk); @(posedge clk);
        set_ctrl(1'b1, 1'b1, 1'b0, 1'b0);
        rd16(v);
        chk("R7 set wins flag", {31'd0, ovf_flag}, 32'd1);
        chk("R7 set wins count", {16'd0, v}, 32'h0011);
        repeat (3) @(negedge clk); ev_in = 1'b1;
        repeat (4) @(negedge clk);
        // R7 writing 1 to bit3 keeps the flag
        set_ctrl(1'b1, 1'b1, 1'b0, 1'b1);
        chk("R7 keep", {31'd0, ovf_flag}, 32'd1);

        // R9 irq gating
        irq_en = 1'b0; #1;
        chk("R9 masked", {31'd0, irq}, 32'd0);
        irq_en = 1'b1; #1;
        chk("R9 raised", {31'd0, irq}, 32'd1);
        set_ctrl(1'b1, 1'b1, 1'b0, 1'b0);
        #1 chk("R9 cleared", {31'd0, irq}, 32'd0);

        // R8 count write beats a step in the same cycle (would-be wrap)
        load16(16'hFFFF);
        @(negedge clk); ev_in = 1'b0;
        @(posedge clk); @(posedge clk);
        wr(3'd0, 8'h55);
        rd16(v);
        chk("R8 count", {16'd0, v}, 32'hFF55);
        chk("R8 flag", {31'd0, ovf_flag}, 32'd0);
        repeat (3) @(negedge clk); ev_in = 1'b1;
        repeat (4) @(negedge clk);
        rdc(c);
        chk("R10 final ctrl", {24'd0, c}, {27'd0, m_ext, 1'b0, 1'b0, 1'b1, 1'b1});

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule